// File: doc/BRIEF.md
# Deduplicating Block Miss Queue

This block sits behind the hit/miss router of a non-blocking texture cache. Each texel address that missed in the cache is reduced to its cache-block address. A block address that is not already pending goes into a first-in first-out queue. A block address that is already pending is accepted and then dropped. Blocks leave the queue one at a time as memory reads toward DRAM or a level-2 cache, and only one read is in flight at any time.

When the memory side returns the eight-word block, the block is broadcast for exactly one cycle on the fill port, together with its block address. Every miss that named that block sees this fill, including the misses that were dropped as duplicates. One memory read therefore serves all of them. Writing the data into the cache array and tracking which texture request waits on which texel belong to the neighbouring logic.

The issue sequencer has three states:
- **IDLE**: nothing is in flight. The transition IDLE→ISSUE happens when the queue is not empty. It pops the head entry into the in-flight register.
- **ISSUE**: the request is offered. The transition ISSUE→WAIT happens when memory accepts the request.
- **WAIT**: the sequencer waits for the data. The transition WAIT→IDLE happens on the response. The fill pulse is raised on the next cycle.

Top module: `dq_block_miss_queue`

## Requirements
- R1: After reset, `miss_ready` is 1, `mem_req_valid` is 0 and `fill_valid` is 0.
- R2: The block address is `miss_addr[ADDR_W-1:5]`. Bits 4:0 select a byte inside the 32-byte block of eight 32-bit words and take no part in any comparison.
- R3: Non-duplicate misses that are accepted are requested from memory in the order they were accepted. `mem_req_addr` carries the block address.
- R4: A miss is a duplicate when its block address matches either of these:
  - a queued entry;
  - the in-flight block, from the cycle it is offered up to and including the cycle its response arrives.
  A duplicate is accepted without creating a new queue entry or a new memory request.
- R5: At most one request is in flight. While `mem_req_ready` is 0, `mem_req_valid` stays high with a stable address. No new request is offered until the previous fill has been broadcast.
- R6: The cycle after `mem_rsp_valid`, `fill_valid` is high for exactly one cycle. In that cycle `fill_addr` holds the in-flight block address and `fill_data` holds the returned block. Word k occupies bits `32k+31:32k`.
- R7: `miss_ready` is 0 only when the queue holds DEPTH entries and the presented address is not a duplicate. A duplicate is still accepted while the queue is full.
- R8: For every accepted miss, duplicates included, a fill for its block address appears after it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A missed texel address is presented |
| miss_addr | input | ADDR_W (32) | Byte address of the missed texel |
| miss_ready | output | 1 | Miss is accepted this cycle when high |
| mem_req_valid | output | 1 | Block read request offered |
| mem_req_addr | output | ADDR_W-5 (27) | Block address of the request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Block data returned for the in-flight request |
| mem_rsp_data | input | 8*WORD_W (256) | Returned block, word 0 in the low bits |
| fill_valid | output | 1 | One-cycle fill broadcast |
| fill_addr | output | ADDR_W-5 (27) | Block address of the fill |
| fill_data | output | 8*WORD_W (256) | Block data of the fill |

## Verification
The assertions assume two things about the memory side:
- `mem_rsp_valid` is raised only while a request is in flight, after its handshake.
- It is raised for a single cycle per request.

The fill-pulse and ordering properties rely on both. The bench's memory model follows this discipline. It answers only while its own reference says a read is outstanding, after a latency of two to five cycles, and it drops the response strobe in the next cycle. `mem_req_ready` is varied freely, and is held low for long stretches to fill the queue and exercise back-pressure.

// File: rtl/dq_pkg.sv
package dq_pkg;

    // Issue sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } issue_st_t;

endpackage

// File: rtl/dq_addr_split.sv
module dq_addr_split #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 5,
    localparam int BLK_W = ADDR_W - OFS_W
) (
    input  logic [ADDR_W-1:0] byte_addr,
    output logic [BLK_W-1:0]  blk_addr
);

    // Drop the offset inside the block
    assign blk_addr = BLK_W'(byte_addr >> OFS_W);

endmodule

// File: rtl/dq_pend_fifo.sv
module dq_pend_fifo #(
    parameter int BLK_W = 27,
    parameter int DEPTH = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [BLK_W-1:0] push_blk,
    input  logic             pop,
    output logic [BLK_W-1:0] head_blk,
    input  logic [BLK_W-1:0] probe_blk,
    output logic             probe_hit,
    output logic             full,
    output logic             empty
);

    logic [BLK_W-1:0] slot_q [DEPTH];
    logic [DEPTH-1:0] live_q;
    logic [DEPTH-1:0] match;
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Associative compare against every live slot
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match[i] = live_q[i] && (slot_q[i] == probe_blk);
    end

    assign probe_hit = |match;
    assign head_blk  = slot_q[rd_q];
    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign empty     = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            wr_q   <= '0;
            rd_q   <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) begin
                slot_q[wr_q] <= push_blk;
                live_q[wr_q] <= 1'b1;
                wr_q         <= bump(wr_q);
            end
            if (pop) begin
                live_q[rd_q] <= 1'b0;
                rd_q         <= bump(rd_q);
            end
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt_q < CNT_W'(DEPTH))) else $error("push into full queue"); // R7

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt_q != '0)) else $error("pop from empty queue"); // R3

    AST_LIVE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(live_q) == int'(cnt_q)) else $error("live slots disagree with count"); // R4

endmodule

// File: rtl/dq_issue_ctrl.sv
module dq_issue_ctrl
    import dq_pkg::*;
#(
    parameter int BLK_W  = 27,
    parameter int DATA_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_empty,
    input  logic [BLK_W-1:0]  q_head,
    output logic              q_pop,
    output logic              req_valid,
    output logic [BLK_W-1:0]  req_addr,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              busy,
    output logic [BLK_W-1:0]  busy_blk,
    output logic              fill_valid,
    output logic [BLK_W-1:0]  fill_addr,
    output logic [DATA_W-1:0] fill_data
);

    issue_st_t        st_q, st_d;
    logic [BLK_W-1:0] fly_q;
    logic             got_rsp;

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (!q_empty)  st_d = ST_ISSUE;
            ST_ISSUE: if (req_ready) st_d = ST_WAIT;
            ST_WAIT:  if (rsp_valid) st_d = ST_IDLE;
            default:                 st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Outputs
    always_comb begin
        q_pop     = 1'b0;
        req_valid = 1'b0;
        got_rsp   = 1'b0;
        busy      = 1'b1;
        unique case (st_q)
            ST_IDLE: begin
                busy  = 1'b0;
                q_pop = !q_empty;
            end
            ST_ISSUE: req_valid = 1'b1;
            ST_WAIT:  got_rsp   = rsp_valid;
            default:  busy      = 1'b0;
        endcase
    end

    assign req_addr = fly_q;
    assign busy_blk = fly_q;

    // In-flight address and fill register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fly_q      <= '0;
            fill_valid <= 1'b0;
            fill_addr  <= '0;
            fill_data  <= '0;
        end else begin
            if (q_pop) fly_q <= q_head;
            fill_valid <= got_rsp;
            if (got_rsp) begin
                fill_addr <= fly_q;
                fill_data <= rsp_data;
            end
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr))) else $error("request dropped"); // R5

    AST_FILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !fill_valid) else $error("fill longer than one cycle"); // R6

    AST_NO_REQ_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT) |=> !req_valid) else $error("second request while waiting"); // R5

    AST_FILL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && st_q == ST_WAIT) |=> (fill_valid && fill_addr == $past(req_addr))) else $error("fill address wrong"); // R6

endmodule

// File: rtl/dq_block_miss_queue.sv
module dq_block_miss_queue #(
    parameter int ADDR_W    = 32,
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 8,
    parameter int DEPTH     = 32,
    localparam int OFS_W    = $clog2(BLK_WORDS * WORD_W / 8),
    localparam int BLK_W    = ADDR_W - OFS_W,
    localparam int DATA_W   = BLK_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              miss_ready,
    output logic              mem_req_valid,
    output logic [BLK_W-1:0]  mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              fill_valid,
    output logic [BLK_W-1:0]  fill_addr,
    output logic [DATA_W-1:0] fill_data
);

    logic [BLK_W-1:0] in_blk;
    logic [BLK_W-1:0] head_blk;
    logic [BLK_W-1:0] busy_blk;
    logic             q_hit, q_full, q_empty, q_pop, q_push;
    logic             busy, dup;

    dq_addr_split #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_split (
        .byte_addr (miss_addr),
        .blk_addr  (in_blk)
    );

    dq_pend_fifo #(.BLK_W(BLK_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_blk  (in_blk),
        .pop       (q_pop),
        .head_blk  (head_blk),
        .probe_blk (in_blk),
        .probe_hit (q_hit),
        .full      (q_full),
        .empty     (q_empty)
    );

    dq_issue_ctrl #(.BLK_W(BLK_W), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .q_empty    (q_empty),
        .q_head     (head_blk),
        .q_pop      (q_pop),
        .req_valid  (mem_req_valid),
        .req_addr   (mem_req_addr),
        .req_ready  (mem_req_ready),
        .rsp_valid  (mem_rsp_valid),
        .rsp_data   (mem_rsp_data),
        .busy       (busy),
        .busy_blk   (busy_blk),
        .fill_valid (fill_valid),
        .fill_addr  (fill_addr),
        .fill_data  (fill_data)
    );

    // Duplicate of a queued entry or of the in-flight block
    assign dup        = q_hit || (busy && (busy_blk == in_blk));
    assign miss_ready = !q_full || dup;
    assign q_push     = miss_valid && !dup && !q_full;

    AST_DUP_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && q_full && busy && busy_blk == in_blk) |-> miss_ready) else $error("duplicate refused"); // R7

endmodule

// File: tb/sim_dq_block_miss_queue.sv
module sim_dq_block_miss_queue;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 32;
    localparam int BW    = 27;
    localparam int DW    = 256;
    localparam int DEPTH = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic [AW-1:0] miss_addr = '0;
    logic          miss_ready;
    logic          mem_req_valid;
    logic [BW-1:0] mem_req_addr;
    logic          mem_req_ready = 1'b0;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic          fill_valid;
    logic [BW-1:0] fill_addr;
    logic [DW-1:0] fill_data;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dq_block_miss_queue u0 (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data)
    );

    int  tests = 0;
    int  fails = 0;
    bit  done  = 0;

    // Reference model state
    logic [BW-1:0] mq[$];
    logic [BW-1:0] waiters[$];
    int            st = 0;    // 0 idle, 1 offered, 2 waiting
    logic [BW-1:0] m_out = '0;
    bit            f_v = 0;
    logic [BW-1:0] f_a = '0;
    int            lat = 0;
    int            m_req = 0;
    int            dut_req = 0;
    logic [31:0]   rng = 32'h1234_5678;

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    function automatic logic [DW-1:0] mk(input logic [BW-1:0] b);
        logic [DW-1:0] d = '0;
        for (int k = 0; k < 8; k++) d[k*32 +: 32] = (32'(b) << 3) + 32'(k) + 32'h5A00_0000;
        return d;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycle(input bit mv, input logic [AW-1:0] a, input bit rdy);
        logic [BW-1:0] b;
        bit dup, er, rv;
        @(negedge clk);
        b  = a[AW-1:5];
        rv = (st == 2 && lat == 0);
        miss_valid    = mv;
        miss_addr     = a;
        mem_req_ready = rdy;
        mem_rsp_valid = rv;
        mem_rsp_data  = rv ? mk(m_out) : '0;
        #1;
        dup = 0;
        foreach (mq[i]) if (mq[i] == b) dup = 1;
        if (st != 0 && m_out == b) dup = 1;
        er = (mq.size() < DEPTH) || dup;
        chk(miss_ready === er, "R7/R4 miss_ready", DW'(miss_ready), DW'(er));
        chk(mem_req_valid === (st == 1), "R5 mem_req_valid", DW'(mem_req_valid), DW'(st == 1));
        if (st == 1)
            chk(mem_req_addr === m_out, "R3/R2 mem_req_addr order", DW'(mem_req_addr), DW'(m_out));
        chk(fill_valid === f_v, "R6 fill_valid", DW'(fill_valid), DW'(f_v));
        if (f_v) begin
            chk(fill_addr === f_a, "R6 fill_addr", DW'(fill_addr), DW'(f_a));
            chk(fill_data === mk(f_a), "R6 fill_data", fill_data, mk(f_a));
            // R8: the fill serves every waiter of this block
            for (int i = waiters.size() - 1; i >= 0; i--)
                if (waiters[i] == f_a) waiters.delete(i);
        end
        if (mem_req_valid && rdy) dut_req++;
        // Advance the model as of the coming edge
        f_v = 0;
        case (st)
            0: if (mq.size() > 0) begin m_out = mq.pop_front(); st = 1; end
            1: if (rdy) begin st = 2; rng = nxt(rng); lat = 2 + int'(rng % 4); m_req++; end
            default: if (rv) begin st = 0; f_v = 1; f_a = m_out; end else lat--;
        endcase
        if (mv && er) begin
            waiters.push_back(b);
            if (!dup) mq.push_back(b);
        end
    endtask

    task automatic drain();
        while (st != 0 || mq.size() > 0 || f_v) cycle(0, '0, 1);
    endtask

    initial begin
        int base;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(miss_ready === 1'b1, "R1 reset miss_ready", DW'(miss_ready), DW'(1));
        chk(mem_req_valid === 1'b0, "R1 reset mem_req_valid", DW'(mem_req_valid), DW'(0));
        chk(fill_valid === 1'b0, "R1 reset fill_valid", DW'(fill_valid), DW'(0));
        rst_n = 1'b1;

        // Fill the queue with memory stalled, then offer a duplicate while full (R7)
        for (int i = 0; i < 40; i++) cycle(1, AW'((i + 1) << 5) | AW'(i & 31), 0);
        cycle(1, AW'(5 << 5) | AW'(3), 0);
        cycle(1, AW'(1 << 5) | AW'(9), 0);
        cycle(1, AW'(900 << 5), 0);
        drain();

        // Random traffic over a small pool of blocks (R2, R3, R4, R5)
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] a;
            bit mv, rdy;
            rng = nxt(rng);
            mv  = rng[0] | rng[1];
            rdy = rng[2] | rng[3];
            a   = (AW'(rng[11:8] % 12) << 5) | AW'(rng[20:16]);
            cycle(mv, a, rdy);
        end
        drain();

        // Five misses to one block at different offsets give one read (R2, R4)
        base = dut_req;
        for (int i = 0; i < 5; i++) cycle(1, AW'(777 << 5) | AW'(i * 7), 1);
        drain();
        chk(dut_req - base == 1, "R4 single read for duplicates", DW'(dut_req - base), DW'(1));

        chk(dut_req == m_req, "R4 total memory reads", DW'(dut_req), DW'(m_req));
        chk(waiters.size() == 0, "R8 every accepted miss filled", DW'(waiters.size()), DW'(0));

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule